// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces the fetch address for an in-order core whose branches carry an architectural delay slot. It holds a current and a following program counter. Each cycle the instruction at the current address is issued, and the execute stage returns its resolved control outcome in the same cycle: whether it is a branch, whether the branch is taken, the target, whether the branch owns a delay slot, whether that slot is annulled on a not-taken outcome, and whether a link value must be written. From this the sequencer chooses the next fetch, marks the issued instruction as live or dead, supplies the link value and records restart information when an exception is reported.

A taken branch never changes the current counter directly. Its target is loaded into the following counter, so the instruction behind the branch still issues before the redirect. Because the pair of counters is the only state, a branch placed in another branch's slot has defined behaviour: exactly one instruction at the first target issues, then fetch moves to the second target. Branches without a slot cost one dead cycle instead, and annulled slots are issued but marked dead when the branch falls through.

Top module: `dslot_pc_seq`

## Requirements
- R1: A synchronous reset sets the fetch address to RESET_VEC with the following counter at RESET_VEC + 4, clears the in-slot, dead-slot and bubble state and clears the saved restart address and its flag; the first cycle after reset issues a live instruction at RESET_VEC.
- R2: Without branches the fetch address advances by 4 per live cycle. A branch with its slot enabled is always followed by a live slot instruction at the old following address, flagged in_slot = 1, and a taken one redirects only on the fetch after that slot.
- R3: The branch target is captured in the cycle the branch issues; the target input presented while any non-branch, dead or stalled instruction is issued has no effect on the fetch stream.
- R4: A branch with its link request set raises link_wr in its issue cycle with link_val equal to the branch address + 8.
- R5: With the annul bit set, a slot behind a taken branch issues live, while a slot behind a not-taken branch is issued with issue_valid = 0; all control inputs during a dead slot are ignored.
- R6: A branch with its slot disabled is followed by one cycle with issue_valid = 0 and in_slot = 0 showing the resolved address (target if taken, branch address + 4 if not), after which that address issues live.
- R7: When the slot instruction is itself a taken slotted branch, exactly one instruction at the first target issues (flagged in_slot), then fetch continues at the second target.
- R8: An exception reported on a live instruction saves a restart address on the next clock: the slot address − 4 with the saved slot flag set when the instruction is in a slot, otherwise its own address with the flag clear.
- R9: Every fetch address has bits [1:0] equal to 0. A taken branch whose target has non-zero bits [1:0] raises align_fault in its issue cycle and is treated as not taken.
- R10: While stall is high, nothing advances, issue_valid, link_wr and align_fault are 0 and branch and exception inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze the sequencer for this cycle |
| br_is | input | 1 | Issued instruction is a branch |
| br_taken | input | 1 | Resolved branch outcome |
| br_target | input | AW | Resolved branch target |
| br_slot | input | 1 | Branch owns a delay slot |
| br_annul | input | 1 | Kill the slot if the branch is not taken |
| br_link | input | 1 | Branch writes a link value |
| exc_req | input | 1 | Issued instruction raised an exception |
| fetch_addr | output | AW | Address of the instruction issued this cycle |
| issue_valid | output | 1 | Issued instruction is live |
| in_slot | output | 1 | Issued instruction sits in a delay slot |
| link_wr | output | 1 | Link value must be written |
| link_val | output | AW | Link value (branch address + 8) |
| align_fault | output | 1 | Taken target is misaligned |
| epc | output | AW | Saved restart address |
| epc_in_slot | output | 1 | Saved exception came from a delay slot |

## Verification
The bench builds the sequencer with a 32-bit address and a reset vector of 0x100, so every address in the scripted stream is short and each redirect, fall-through and link value can be read straight off the table. This choice brings back-to-back slotted branches, annulled slots under both outcomes, slotless branches under both outcomes, a misaligned target and an exception in a slot into a run of about twenty cycles, with a reset in the middle of a pending redirect added as a directed case.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    // Kind of the cycle currently being issued
    typedef enum logic [1:0] {
        CYC_NORM   = 2'd0,  // live, not behind a branch
        CYC_SLOT   = 2'd1,  // live delay-slot instruction
        CYC_SQUASH = 2'd2,  // annulled delay-slot instruction
        CYC_BUBBLE = 2'd3   // dead cycle after a slotless branch
    } cyc_e;

endpackage

// File: rtl/dslot_redirect.sv
module dslot_redirect
    import dslot_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] cur_npc,
    input  logic          is_br,
    input  logic          taken,
    input  logic [AW-1:0] target,
    input  logic          slot_en,
    input  logic          annul,
    input  logic          link,
    output logic [AW-1:0] nxt_pc,
    output logic [AW-1:0] nxt_npc,
    output cyc_e          nxt_kind,
    output logic          fault,
    output logic          link_wr,
    output logic [AW-1:0] link_val
);

    localparam logic [AW-1:0] STEP = AW'(4);

    logic          go;
    logic [AW-1:0] resolved;

    always_comb begin
        fault    = is_br && taken && (target[1:0] != 2'b00);
        go       = is_br && taken && !fault;
        resolved = go ? target : (cur_pc + STEP);
        link_wr  = is_br && link;
        link_val = cur_pc + (STEP << 1);

        if (!is_br) begin
            nxt_pc   = cur_npc;
            nxt_npc  = cur_npc + STEP;
            nxt_kind = CYC_NORM;
        end else if (slot_en) begin
            // slot issues from the following counter; target waits behind it
            nxt_pc   = cur_npc;
            nxt_npc  = go ? target : (cur_npc + STEP);
            nxt_kind = (annul && !go) ? CYC_SQUASH : CYC_SLOT;
        end else begin
            // slotless: show the resolved address dead for one cycle
            nxt_pc   = resolved;
            nxt_npc  = resolved + STEP;
            nxt_kind = CYC_BUBBLE;
        end
    end

endmodule

// File: rtl/dslot_epc.sv
module dslot_epc #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exc_valid,
    input  logic          in_slot,
    input  logic [AW-1:0] cur_pc,
    output logic [AW-1:0] epc,
    output logic          epc_in_slot
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          slot;
    } epc_t;

    epc_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (exc_valid) begin
            rec_d.addr = in_slot ? (cur_pc - AW'(4)) : cur_pc;
            rec_d.slot = in_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end

    assign epc         = rec_q.addr;
    assign epc_in_slot = rec_q.slot;

    p_epc_slot_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && in_slot) |=> epc_in_slot);

    p_epc_plain_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !in_slot) |=> !epc_in_slot);

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dslot_pkg::*;
#(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   RESET_VEC = AW'(32'h0000_0100)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic          br_is,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          br_slot,
    input  logic          br_annul,
    input  logic          br_link,
    input  logic          exc_req,
    output logic [AW-1:0] fetch_addr,
    output logic          issue_valid,
    output logic          in_slot,
    output logic          link_wr,
    output logic [AW-1:0] link_val,
    output logic          align_fault,
    output logic [AW-1:0] epc,
    output logic          epc_in_slot
);

    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
        cyc_e          kind;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          live;
    logic [AW-1:0] rd_pc, rd_npc;
    cyc_e          rd_kind;
    logic          rd_fault, rd_link_wr;
    logic [AW-1:0] rd_link_val;

    dslot_redirect #(.AW(AW)) u_redirect (
        .cur_pc   (seq_q.pc),
        .cur_npc  (seq_q.npc),
        .is_br    (br_is),
        .taken    (br_taken),
        .target   (br_target),
        .slot_en  (br_slot),
        .annul    (br_annul),
        .link     (br_link),
        .nxt_pc   (rd_pc),
        .nxt_npc  (rd_npc),
        .nxt_kind (rd_kind),
        .fault    (rd_fault),
        .link_wr  (rd_link_wr),
        .link_val (rd_link_val)
    );

    always_comb begin
        live  = !stall && (seq_q.kind == CYC_NORM || seq_q.kind == CYC_SLOT);
        seq_d = seq_q;
        if (!stall) begin
            unique case (seq_q.kind)
                CYC_SQUASH: begin
                    seq_d.pc   = seq_q.npc;
                    seq_d.npc  = seq_q.npc + STEP;
                    seq_d.kind = CYC_NORM;
                end
                CYC_BUBBLE: begin
                    seq_d.kind = CYC_NORM;
                end
                default: begin
                    seq_d.pc   = rd_pc;
                    seq_d.npc  = rd_npc;
                    seq_d.kind = rd_kind;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.pc   <= RESET_VEC;
            seq_q.npc  <= RESET_VEC + STEP;
            seq_q.kind <= CYC_NORM;
        end else begin
            seq_q <= seq_d;
        end
    end

    dslot_epc #(.AW(AW)) u_epc (
        .clk         (clk),
        .rst         (rst),
        .exc_valid   (live && exc_req),
        .in_slot     (in_slot),
        .cur_pc      (seq_q.pc),
        .epc         (epc),
        .epc_in_slot (epc_in_slot)
    );

    assign fetch_addr  = seq_q.pc;
    assign issue_valid = live;
    assign in_slot     = (seq_q.kind == CYC_SLOT) || (seq_q.kind == CYC_SQUASH);
    assign link_wr     = live && rd_link_wr;
    assign link_val    = rd_link_val;
    assign align_fault = live && rd_fault;

    p_fetch_word_r9: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[1:0] == 2'b00);

    p_stall_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(fetch_addr));

    p_slot_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && br_is && br_slot) |=> in_slot);

    p_annul_squash_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && br_is && br_slot && br_annul && !br_taken) |=> !issue_valid);

    p_noslot_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && br_is && !br_slot) |=> (!issue_valid && !in_slot));

endmodule

// File: tb/dslot_pc_seq_bench.sv
`timescale 1ns/1ps
module dslot_pc_seq_bench;

    localparam int          AW  = 32;
    localparam logic [31:0] VEC = 32'h100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0, br_is = 1'b0, br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          br_slot = 1'b0, br_annul = 1'b0, br_link = 1'b0, exc_req = 1'b0;
    logic [AW-1:0] fetch_addr, link_val, epc;
    logic          issue_valid, in_slot, link_wr, align_fault, epc_in_slot;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dslot_pc_seq #(.AW(AW), .RESET_VEC(VEC)) u_dslot_pc_seq (
        .clk, .rst, .stall, .br_is, .br_taken, .br_target, .br_slot,
        .br_annul, .br_link, .exc_req, .fetch_addr, .issue_valid, .in_slot,
        .link_wr, .link_val, .align_fault, .epc, .epc_in_slot
    );

    typedef struct packed {
        logic        st, ex, br, tk, sl, an, lk;
        logic [31:0] tgt;
        logic [31:0] addr;
        logic        v, is, lw;
        logic [31:0] lv;
        logic        fl;
        logic [31:0] ep;
        logic        es;
    } row_t;

    // st ex br tk sl an lk  tgt    | addr   v  is lw  lv     fl  epc    es
    localparam row_t TBL [22] = '{
        '{0,0,0,0,0,0,0, 32'h000, 32'h100,1,0,0, 32'h000,0, 32'h000,0}, // R1 R2
        '{0,0,1,1,1,0,1, 32'h200, 32'h104,1,0,1, 32'h10C,0, 32'h000,0}, // R4 R2
        '{0,0,0,0,0,0,0, 32'h300, 32'h108,1,1,0, 32'h000,0, 32'h000,0}, // R2 R3
        '{0,0,1,0,1,1,0, 32'h400, 32'h200,1,0,0, 32'h000,0, 32'h000,0}, // R3 R5
        '{0,1,1,1,1,0,1, 32'h500, 32'h204,0,1,0, 32'h000,0, 32'h000,0}, // R5 dead
        '{0,0,1,1,1,1,0, 32'h600, 32'h208,1,0,0, 32'h000,0, 32'h000,0}, // R5
        '{0,0,0,0,0,0,0, 32'h000, 32'h20C,1,1,0, 32'h000,0, 32'h000,0}, // R5 live
        '{0,0,1,1,0,0,0, 32'h700, 32'h600,1,0,0, 32'h000,0, 32'h000,0}, // R6
        '{0,0,0,0,0,0,0, 32'h000, 32'h700,0,0,0, 32'h000,0, 32'h000,0}, // R6 bubble
        '{0,0,1,0,0,0,0, 32'h800, 32'h700,1,0,0, 32'h000,0, 32'h000,0}, // R6
        '{0,0,0,0,0,0,0, 32'h000, 32'h704,0,0,0, 32'h000,0, 32'h000,0}, // R6 bubble
        '{0,0,1,1,1,0,0, 32'h900, 32'h704,1,0,0, 32'h000,0, 32'h000,0}, // R7
        '{0,0,1,1,1,0,0, 32'hA00, 32'h708,1,1,0, 32'h000,0, 32'h000,0}, // R7 branch in slot
        '{0,0,0,0,0,0,0, 32'h000, 32'h900,1,1,0, 32'h000,0, 32'h000,0}, // R7 one at target
        '{0,0,1,1,1,0,0, 32'hA02, 32'hA00,1,0,0, 32'h000,1, 32'h000,0}, // R7 R9
        '{0,0,0,0,0,0,0, 32'h000, 32'hA04,1,1,0, 32'h000,0, 32'h000,0}, // R9 fall-through
        '{1,1,1,1,1,0,1, 32'hB00, 32'hA08,0,0,0, 32'h000,0, 32'h000,0}, // R10
        '{0,0,0,0,0,0,0, 32'h000, 32'hA08,1,0,0, 32'h000,0, 32'h000,0}, // R10 R3
        '{0,0,1,1,1,0,0, 32'hC00, 32'hA0C,1,0,0, 32'h000,0, 32'h000,0}, // R2
        '{0,1,0,0,0,0,0, 32'h000, 32'hA10,1,1,0, 32'h000,0, 32'h000,0}, // R8
        '{0,1,0,0,0,0,0, 32'h000, 32'hC00,1,0,0, 32'h000,0, 32'hA0C,1}, // R8
        '{0,0,0,0,0,0,0, 32'h000, 32'hC04,1,0,0, 32'h000,0, 32'hC00,0}  // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input row_t r);
        stall = r.st; exc_req = r.ex; br_is = r.br; br_taken = r.tk;
        br_slot = r.sl; br_annul = r.an; br_link = r.lk; br_target = r.tgt;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset fetch", fetch_addr, VEC);
        chk("R1 reset in_slot", 32'(in_slot), 32'd0);
        chk("R1 reset epc", epc, 32'd0);

        for (int i = 0; i < 22; i++) begin
            drive(TBL[i]);
            #1;
            chk($sformatf("row %0d addr R2", i), fetch_addr, TBL[i].addr);
            chk($sformatf("row %0d valid R5 R6", i), 32'(issue_valid), 32'(TBL[i].v));
            chk($sformatf("row %0d in_slot R7", i), 32'(in_slot), 32'(TBL[i].is));
            chk($sformatf("row %0d link_wr R4", i), 32'(link_wr), 32'(TBL[i].lw));
            if (TBL[i].lw) chk($sformatf("row %0d link_val R4", i), link_val, TBL[i].lv);
            chk($sformatf("row %0d fault R9", i), 32'(align_fault), 32'(TBL[i].fl));
            chk($sformatf("row %0d epc R8", i), epc, TBL[i].ep);
            chk($sformatf("row %0d epc_slot R8", i), 32'(epc_in_slot), 32'(TBL[i].es));
            @(negedge clk);
        end

        // R1: reset while a taken redirect is pending
        drive('{0,0,1,1,1,0,0, 32'hD00, 32'h0,0,0,0, 32'h0,0, 32'h0,0});
        @(negedge clk);
        drive('0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 mid reset fetch", fetch_addr, VEC);
        chk("R1 mid reset in_slot", 32'(in_slot), 32'd0);
        chk("R1 mid reset epc", epc, 32'd0);
        chk("R1 mid reset epc flag", 32'(epc_in_slot), 32'd0);
        @(negedge clk);
        #1;
        chk("R1 R2 after reset step", fetch_addr, VEC + 32'd4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule